// File: doc/BRIEF.md
# Serial Transmitter with Automatic RS485 Line-Turnaround

This block is the transmit half of a UART that runs a half-duplex RS485 transceiver by itself. Software sets a baud divisor, picks 16x or 13x oversampling and writes bytes into a single holding register through a small byte-wide register port. Each byte goes out as an 8N1 frame on `tx`. While automatic direction control is on, the block drives the request-to-send output (`rts`) to its active level around every frame, with no per-frame action from software.

The active period starts one bit period ahead of the start bit and lasts three bit periods past the end of the stop bit. The extra time lets the stop bit clear the transceiver before the line turns round. A byte written during that three-bit tail starts a new frame and keeps `rts` active through it. With automatic control off, `rts` simply follows a software-written level.

Top module: `uart_dir_tx`

## Requirements
- R1: After reset, `tx` is 1 and `rts` is 0. Control, divisor and mode registers read 0, and the status register reads 0x01.
- R2: Register map (6-bit byte address): 0x00 is the transmit holding register (write only). 0x01 is control: bit 0 = 1 selects 13x oversampling, and bit 1 is the manual `rts` level. 0x02 and 0x03 hold the low and high divisor bytes. 0x04 is status, with bit 0 = transmit empty. 0x20 is mode: bit 4 enables automatic direction control and bit 3 is polarity. Written registers read back unchanged, and unmapped addresses read 0.
- R3: Each frame is one start bit (0), eight data bits sent LSB first, and one stop bit (1), each lasting P = divisor×16 cycles (or divisor×13 in 13x mode). `tx` is 1 whenever no frame is being sent.
- R4: With the holding-register write captured at clock edge 0, the block is busy from edge 1 on. The start bit begins at edge 1+P, so `rts` is active for a full bit period before it.
- R5: The stop bit ends at edge 1+11P. With no further byte, `rts` stays active until edge 1+14P and is inactive from then on.
- R6: In automatic mode the active `rts` level equals the polarity bit: 0 drives `rts` low while sending, and 1 drives it high. The inactive level is the inverse of the polarity bit.
- R7: With automatic control disabled, `rts` equals control bit 1 at all times, whatever the polarity bit and the state of transmission.
- R8: A byte written while in the three-bit hold starts a new lead phase at the following edge, and `rts` stays active without a gap.
- R9: While the divisor is 0, no frame starts, `tx` stays 1 and automatic `rts` stays inactive. A pending byte starts at the edge after the divisor becomes nonzero, with the timing of R4.
- R10: A write to the holding register while it is already full is ignored.
- R11: Status bit 0 is 1 only when the holding register is empty and no frame bit is being shifted. It is 0 from the holding-register write until the stop bit ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address (read and write) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tx | output | 1 | Serial data out, idle high |
| rts | output | 1 | Transceiver direction (driver enable) |

## Verification
The assertions assume that polarity and enable stay unchanged while a frame is in flight. They also assume that the divisor is not changed mid-frame, since changing it would alter the bit period partway through. The bench reprograms the mode, control and divisor registers only while the transmitter is idle, after the three-bit hold has run out. Its only mid-frame writes go to the holding register, which is exactly what the lead, hold and ignored-write checks cover. Divisors stay small (1 to 3), so every cycle of each frame can be compared against a closed-form timeline.

// File: rtl/uart_dir_pkg.sv
package uart_dir_pkg;
    localparam int ADDR_W = 6;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] A_THR  = 6'h00;
    localparam logic [ADDR_W-1:0] A_CTRL = 6'h01;
    localparam logic [ADDR_W-1:0] A_DIVL = 6'h02;
    localparam logic [ADDR_W-1:0] A_DIVH = 6'h03;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] A_MODE = 6'h20;

    localparam int CTRL_OS13_BIT = 0;
    localparam int CTRL_MAN_BIT  = 1;
    localparam int MODE_POL_BIT  = 3;
    localparam int MODE_EN_BIT   = 4;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_LEAD  = 2'd1,
        TX_SHIFT = 2'd2,
        TX_HOLD  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/uart_dir_regs.sv
module uart_dir_regs
    import uart_dir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              tx_empty,
    output logic              thr_wr,
    output logic [BYTE_W-1:0] thr_wdata,
    output logic [2*BYTE_W-1:0] div,
    output logic              os13,
    output logic              man_rts,
    output logic              dir_en,
    output logic              dir_pol
);
    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] div_lo;
        logic [BYTE_W-1:0] div_hi;
        logic [BYTE_W-1:0] mode;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                A_CTRL:  r_d.ctrl   = wdata;
                A_DIVL:  r_d.div_lo = wdata;
                A_DIVH:  r_d.div_hi = wdata;
                A_MODE:  r_d.mode   = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = r_q.ctrl;
            A_DIVL:  rdata = r_q.div_lo;
            A_DIVH:  rdata = r_q.div_hi;
            A_STAT:  rdata = {{(BYTE_W-1){1'b0}}, tx_empty};
            A_MODE:  rdata = r_q.mode;
            default: rdata = '0;
        endcase
    end

    assign thr_wr    = wr && (addr == A_THR);
    assign thr_wdata = wdata;
    assign div       = {r_q.div_hi, r_q.div_lo};
    assign os13      = r_q.ctrl[CTRL_OS13_BIT];
    assign man_rts   = r_q.ctrl[CTRL_MAN_BIT];
    assign dir_en    = r_q.mode[MODE_EN_BIT];
    assign dir_pol   = r_q.mode[MODE_POL_BIT];
endmodule

// File: rtl/uart_dir_baud.sv
module uart_dir_baud #(
    parameter int DIV_W = 16,
    parameter int OS_HI = 16,
    parameter int OS_LO = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             os13,
    input  logic             restart,
    output logic             tick
);
    localparam int CNT_W = DIV_W + $clog2(OS_HI + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] period;
    logic             div_nz;
    logic             at_end;

    always_comb begin
        period = {{(CNT_W-DIV_W){1'b0}}, div} * (os13 ? CNT_W'(OS_LO) : CNT_W'(OS_HI));
        div_nz = (div != '0);
        at_end = div_nz && (cnt_q >= period - CNT_W'(1));
        tick   = at_end && !restart;
        if (restart || !div_nz || at_end) cnt_d = '0;
        else                              cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_dir_txfsm.sv
module uart_dir_txfsm
    import uart_dir_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int LEAD_BITS = 1,
    parameter int HOLD_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 thr_wr,
    input  logic [DATA_BITS-1:0] thr_wdata,
    input  logic                 tick,
    input  logic                 div_nz,
    output logic                 restart,
    output tx_state_e            state,
    output logic                 thr_full,
    output logic [DATA_BITS-1:0] thr_data,
    output logic                 tx,
    output logic                 busy,
    output logic                 tx_empty
);
    localparam int FRAME   = DATA_BITS + 2;
    localparam int BC_W    = $clog2(FRAME);
    localparam int GAP_MAX = (LEAD_BITS > HOLD_BITS) ? LEAD_BITS : HOLD_BITS;
    localparam int GC_W    = $clog2(GAP_MAX + 1);

    typedef struct packed {
        tx_state_e            st;
        logic                 full;
        logic [DATA_BITS-1:0] hold;
        logic [FRAME-1:0]     sh;
        logic [BC_W-1:0]      bitcnt;
        logic [GC_W-1:0]      gapcnt;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        restart = s_q.full && ((s_q.st == TX_IDLE && div_nz) || s_q.st == TX_HOLD);
    end

    always_comb begin
        s_d = s_q;
        if (thr_wr && !s_q.full) begin
            s_d.full = 1'b1;
            s_d.hold = thr_wdata;
        end
        case (s_q.st)
            TX_IDLE: begin
                if (restart) begin
                    s_d.st     = TX_LEAD;
                    s_d.gapcnt = '0;
                end
            end
            TX_LEAD: begin
                if (tick) begin
                    if (s_q.gapcnt == GC_W'(LEAD_BITS - 1)) begin
                        s_d.st     = TX_SHIFT;
                        s_d.sh     = {1'b1, s_q.hold, 1'b0};
                        s_d.full   = 1'b0;
                        s_d.bitcnt = '0;
                    end else begin
                        s_d.gapcnt = s_q.gapcnt + GC_W'(1);
                    end
                end
            end
            TX_SHIFT: begin
                if (tick) begin
                    if (s_q.bitcnt == BC_W'(FRAME - 1)) begin
                        s_d.st     = TX_HOLD;
                        s_d.gapcnt = '0;
                    end else begin
                        s_d.sh     = {1'b1, s_q.sh[FRAME-1:1]};
                        s_d.bitcnt = s_q.bitcnt + BC_W'(1);
                    end
                end
            end
            TX_HOLD: begin
                if (restart) begin
                    s_d.st     = TX_LEAD;
                    s_d.gapcnt = '0;
                end else if (tick) begin
                    if (s_q.gapcnt == GC_W'(HOLD_BITS - 1)) s_d.st = TX_IDLE;
                    else s_d.gapcnt = s_q.gapcnt + GC_W'(1);
                end
            end
            default: s_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= TX_IDLE;
            s_q.sh <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign state    = s_q.st;
    assign thr_full = s_q.full;
    assign thr_data = s_q.hold;
    assign tx       = (s_q.st == TX_SHIFT) ? s_q.sh[0] : 1'b1;
    assign busy     = (s_q.st != TX_IDLE);
    assign tx_empty = !s_q.full && (s_q.st == TX_IDLE || s_q.st == TX_HOLD);
endmodule

// File: rtl/uart_dir_tx.sv
module uart_dir_tx
    import uart_dir_pkg::*;
#(
    parameter int LEAD_BITS = 1,
    parameter int HOLD_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              tx,
    output logic              rts
);
    localparam int DIV_W = 2 * BYTE_W;

    logic              thr_wr;
    logic [BYTE_W-1:0] thr_wdata;
    logic [DIV_W-1:0]  div;
    logic              os13, man_rts, dir_en, dir_pol;
    logic              tick, restart, thr_full, busy, tx_empty;
    logic [BYTE_W-1:0] thr_data;
    tx_state_e         st;

    uart_dir_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .tx_empty(tx_empty), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
        .div(div), .os13(os13), .man_rts(man_rts), .dir_en(dir_en), .dir_pol(dir_pol)
    );

    uart_dir_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div), .os13(os13), .restart(restart), .tick(tick)
    );

    uart_dir_txfsm #(
        .DATA_BITS(BYTE_W), .LEAD_BITS(LEAD_BITS), .HOLD_BITS(HOLD_BITS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_wdata(thr_wdata), .tick(tick),
        .div_nz(div != '0), .restart(restart), .state(st), .thr_full(thr_full),
        .thr_data(thr_data), .tx(tx), .busy(busy), .tx_empty(tx_empty)
    );

    always_comb begin
        if (dir_en) rts = busy ? dir_pol : !dir_pol;
        else        rts = man_rts;
    end
endmodule

// File: rtl/uart_dir_tx_chk.sv
module uart_dir_tx_chk
    import uart_dir_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tx,
    input logic        rts,
    input tx_state_e   st,
    input logic        tick,
    input logic        thr_wr,
    input logic        thr_full,
    input logic [7:0]  thr_data,
    input logic [15:0] div,
    input logic        dir_en,
    input logic        dir_pol,
    input logic        tx_empty
);
    AST_RTS_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_en && $stable(dir_en) && $stable(dir_pol) && $fell(tx)) |-> ($past(rts) == dir_pol)); // R4

    AST_RELEASE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_en && $stable(dir_en) && $stable(dir_pol) && !$stable(rts) && rts != dir_pol) |-> tx_empty); // R5

    AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx); // R11

    AST_NO_START_DIV0: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0 && st == TX_IDLE) |=> (st == TX_IDLE)); // R9

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SHIFT && $past(st) == TX_LEAD) |-> $past(tick)); // R4

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && thr_full && st != TX_LEAD) |=> (thr_data == $past(thr_data))); // R10
endmodule

bind uart_dir_tx uart_dir_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx(tx), .rts(rts), .st(st), .tick(tick),
    .thr_wr(thr_wr), .thr_full(thr_full), .thr_data(thr_data), .div(div),
    .dir_en(dir_en), .dir_pol(dir_pol), .tx_empty(tx_empty)
);

// File: tb/uart_dir_tx_tb.sv
`timescale 1ns/1ps
module uart_dir_tx_tb;
    import uart_dir_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = A_STAT;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx, rts;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_dir_tx u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx(tx), .rts(rts)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic read_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a; #1;
        chk(tag, $sformatf("read addr %0h", a), 16'(reg_rdata), 16'(exp));
        reg_addr = A_STAT;
    endtask

    task automatic cfg(input int dv, input logic os13, input logic man, input logic en, input logic pol);
        bus_write(A_DIVH, 8'(dv >> 8));
        bus_write(A_CTRL, {6'b0, man, os13});
        bus_write(A_MODE, {3'b0, en, pol, 3'b0});
        bus_write(A_DIVL, 8'(dv));
    endtask

    // Called right after the trigger edge (edge 0); compares every cycle up to last_n.
    task automatic check_frame(input logic [7:0] d, input int p, input logic auto_en,
                               input logic lvl, input logic prev_busy, input int last_n,
                               input int inj_n, input string ctx);
        int lead_end, shift_end, hold_end;
        lead_end  = 1 + p;
        shift_end = 1 + 11 * p;
        hold_end  = 1 + 14 * p;
        for (int n = 0; n <= last_n; n++) begin
            logic e_tx, e_rts, e_empty, bsy;
            if (n > 0) begin
                @(posedge clk); #1;
            end
            if (reg_wr) begin reg_wr = 1'b0; reg_addr = A_STAT; end
            #1;
            e_tx = 1'b1;
            if (n >= lead_end && n < shift_end) begin
                int k;
                k = (n - lead_end) / p;
                e_tx = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : d[k-1];
            end
            bsy     = (n >= 1 && n < hold_end) || (prev_busy && n == 0);
            e_rts   = auto_en ? (bsy ? lvl : !lvl) : lvl;
            e_empty = (n >= shift_end);
            chk("R3", $sformatf("%s tx n=%0d", ctx, n), 16'(tx), 16'(e_tx));
            chk(auto_en ? "R4" : "R7", $sformatf("%s rts n=%0d", ctx, n), 16'(rts), 16'(e_rts));
            chk("R11", $sformatf("%s empty n=%0d", ctx, n), 16'(reg_rdata[0]), 16'(e_empty));
            if (n == inj_n) begin
                reg_wr = 1'b1; reg_addr = A_THR; reg_wdata = ~d;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "tx", 16'(tx), 16'd1);
        chk("R1", "rts", 16'(rts), 16'd0);
        read_chk("R1", A_STAT, 8'h01);
        read_chk("R1", A_CTRL, 8'h00);
        read_chk("R1", A_MODE, 8'h00);
        read_chk("R1", A_DIVL, 8'h00);
        read_chk("R1", A_DIVH, 8'h00);

        // R2 register readback
        bus_write(A_DIVL, 8'h5A);
        bus_write(A_DIVH, 8'hC3);
        bus_write(A_CTRL, 8'h03);
        bus_write(A_MODE, 8'h18);
        read_chk("R2", A_DIVL, 8'h5A);
        read_chk("R2", A_DIVH, 8'hC3);
        read_chk("R2", A_CTRL, 8'h03);
        read_chk("R2", A_MODE, 8'h18);
        read_chk("R2", 6'h11, 8'h00);
        bus_write(A_DIVL, 8'h00);
        bus_write(A_DIVH, 8'h00);

        // R3 R4 R5 R6 sweep; R10 ignored write injected in lead phase for div 2
        for (int dv = 1; dv <= 3; dv++) begin
            for (int os = 0; os <= 1; os++) begin
                for (int pl = 0; pl <= 1; pl++) begin
                    logic [7:0] d;
                    int p;
                    d = 8'(dv * 53 + os * 29 + pl * 101 + 7);
                    p = dv * ((os == 1) ? 13 : 16);
                    cfg(dv, os[0], 1'b0, 1'b1, pl[0]);
                    bus_write(A_THR, d);
                    check_frame(d, p, 1'b1, pl[0], 1'b0, 14 * p + 3, (dv == 2) ? 2 : -1,
                                (dv == 2) ? "R6 R10 R5" : "R6 R5");
                end
            end
        end

        // R7 manual rts, polarity bit ignored while disabled
        cfg(1, 1'b0, 1'b1, 1'b0, 1'b0);
        bus_write(A_THR, 8'hB4);
        check_frame(8'hB4, 16, 1'b0, 1'b1, 1'b0, 14 * 16 + 3, -1, "R7 man1");
        cfg(1, 1'b1, 1'b0, 1'b0, 1'b1);
        bus_write(A_THR, 8'h2D);
        check_frame(8'h2D, 13, 1'b0, 1'b0, 1'b0, 14 * 13 + 3, -1, "R7 man0");

        // R8 back-to-back write during hold
        cfg(1, 1'b0, 1'b0, 1'b1, 1'b1);
        bus_write(A_THR, 8'hE1);
        check_frame(8'hE1, 16, 1'b1, 1'b1, 1'b0, 1 + 12 * 16, -1, "R8 first");
        bus_write(A_THR, 8'h1E);
        check_frame(8'h1E, 16, 1'b1, 1'b1, 1'b1, 14 * 16 + 3, -1, "R8 second");

        // R9 divisor zero holds the frame back
        cfg(0, 1'b1, 1'b0, 1'b1, 1'b0);
        bus_write(A_THR, 8'h96);
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #2;
            chk("R9", "rts div0", 16'(rts), 16'd1);
            chk("R9", "tx div0", 16'(tx), 16'd1);
            chk("R9", "empty div0", 16'(reg_rdata[0]), 16'd0);
        end
        bus_write(A_DIVL, 8'd2);
        check_frame(8'h96, 26, 1'b1, 1'b0, 1'b0, 14 * 26 + 3, -1, "R9 release");

        read_chk("R11", A_STAT, 8'h01);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule